// File: doc/BRIEF.md
# Three-Line Serial Command Slave

This block is the serial front end of a general-purpose port expander. A master drives three lines: a select line that separates command bytes from data bytes, a serial clock, and one data line. The data line is bidirectional at the pads, so the block offers separate input, output and output-enable signals. The block brings all three lines into the system clock domain, collects 8-bit opcodes, and turns each accepted command into a single-cycle strobe on a plain register bus. The port registers and the interrupt logic sit behind that bus. For reads the block also shifts the returned byte back to the master.

Several chips can share the serial lines. Each chip holds a 3-bit chip-address register that resets to zero. Every command other than the address write and the software reset is accepted only while that register equals the three strap pins. A two-byte pattern triggers a software reset. A single opcode with no data byte requests that the interrupt event flags be cleared.

Top module: `tri_serial_slave`

## Requirements
- R1: With select high, bits on the data line are taken most significant bit first, one on each rising serial clock edge, to form an 8-bit opcode. Select low marks the data phase that follows.
- R2: While the chip address matches, an opcode in 00h..1Fh other than 13h, followed by 8 data bits, gives exactly one `busWr` pulse with `busAddr` equal to the opcode and `busWdata` equal to the data byte.
- R3: While the chip address matches, an opcode in 30h..4Fh gives one `busRd` pulse with `busAddr` equal to the opcode. In the data phase the returned byte leaves MSB first: a new bit appears after each rising serial clock edge and is valid at the falling edge that follows.
- R4: `sdoEn` is high only while select is low after an accepted read opcode. It is low at all other times.
- R5: Opcode FDh followed by a data byte loads bits 2:0 of that byte into the chip-address register, whether or not the address currently matches.
- R6: While the chip address differs from `strapAddr`, every command except FDh and FEh is ignored. No bus strobe and no `evtClr` is produced, and `sdoEn` stays low.
- R7: Opcode FEh followed by data FFh gives one `softRst` pulse and clears the chip-address register. FEh followed by any other byte has no effect.
- R8: Opcode 13h, with no data byte, gives one `evtClr` pulse while the address matches.
- R9: Any opcode outside the write class, the read class, 13h, FDh and FEh (for example 20h..2Fh, 50h and above, except FDh and FEh) gives no strobe, and `sdoEn` stays low.
- R10: `busWr`, `busRd`, `evtClr` and `softRst` are single-cycle pulses, and at most one of them is high in any cycle.
- R11: Each change of the select line discards any partly received byte. After the change, a full command is taken correctly.
- R12: After `rstN` the chip-address register is 0, all strobes are low and `sdoEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapAddr | input | 3 | Chip address strap pins |
| selIn | input | 1 | Select line: high for command, low for data |
| sclkIn | input | 1 | Serial clock from the master |
| sdiIn | input | 1 | Serial data from the pad |
| sdoOut | output | 1 | Serial data toward the pad |
| sdoEn | output | 1 | Output enable of the serial data pad |
| busAddr | output | 8 | Register bus address (the opcode) |
| busWdata | output | 8 | Register bus write data |
| busWr | output | 1 | Register bus write strobe |
| busRd | output | 1 | Register bus read strobe |
| busRdata | input | 8 | Register bus read data, valid in the `busRd` cycle |
| evtClr | output | 1 | Pulse that clears the event status registers |
| softRst | output | 1 | Pulse that returns the control registers to 0 |

## Verification
A wrong bit counter or a stale shift register shows up on the next transaction: the bus strobe carries a wrong address or data byte, or is missing entirely, within about five system cycles of the eighth rising serial edge. A chip-address register in the wrong state makes commands disappear or slip through, and this is visible on the strobe outputs at the end of the very next command. A read path that is off by a bit is caught on the first returned byte, because the read sweep uses a different byte value for every read opcode.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OP_ADDR   = 8'hFD;
  localparam logic [BYTE_W-1:0] OP_RESET  = 8'hFE;
  localparam logic [BYTE_W-1:0] RESET_KEY = 8'hFF;
  localparam logic [BYTE_W-1:0] OP_EVTCLR = 8'h13;
  localparam logic [BYTE_W-1:0] WR_LAST   = 8'h1F;
  localparam logic [BYTE_W-1:0] RD_FIRST  = 8'h30;
  localparam logic [BYTE_W-1:0] RD_LAST   = 8'h4F;

  typedef struct packed {
    logic shiftIn;   // take the synced data bit into the input byte
    logic latchOp;   // hold the completed command byte
    logic loadOut;   // load the read byte from the bus
    logic shiftOut;  // present the next read bit
    logic wrAddr;    // load the chip-address register
    logic clrAddr;   // clear the chip-address register
  } dpStrobe_t;

  function automatic logic isWriteOp(logic [BYTE_W-1:0] op);
    return (op <= WR_LAST) && (op != OP_EVTCLR);
  endfunction

  function automatic logic isReadOp(logic [BYTE_W-1:0] op);
    return (op >= RD_FIRST) && (op <= RD_LAST);
  endfunction
endpackage

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic [BYTE_W-1:0] inByte,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              addrMatch,
  output dpStrobe_t         stb,
  output logic              sdiSync,
  output logic              selSync,
  output logic              busWr,
  output logic              busRd,
  output logic              evtClr,
  output logic              softRst,
  output logic              sdoEn
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic [2:0] sclkSh, selSh;
  logic [1:0] sdiSh;
  logic [CNT_W-1:0] bitCnt;
  logic sclkRise, selEdge, byteEnd;
  logic cmdDone, dataDone, wrArm, readActive;
  logic cmdAddr, cmdReset, cmdClr, cmdWr, cmdRd;
  logic opIsAddr, opIsReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSh <= '0;
      selSh  <= '0;
      sdiSh  <= '0;
    end else begin
      sclkSh <= {sclkSh[1:0], sclkIn};
      selSh  <= {selSh[1:0], selIn};
      sdiSh  <= {sdiSh[0], sdiIn};
    end
  end

  assign sclkRise = sclkSh[1] & ~sclkSh[2];
  assign selEdge  = selSh[1] ^ selSh[2];
  assign selSync  = selSh[1];
  assign sdiSync  = sdiSh[1];
  assign byteEnd  = sclkRise && !selEdge && (bitCnt == LAST_BIT);

  // decode of the byte just completed in the command phase
  assign cmdAddr  = (inByte == OP_ADDR);
  assign cmdReset = (inByte == OP_RESET);
  assign cmdClr   = (inByte == OP_EVTCLR);
  assign cmdWr    = isWriteOp(inByte);
  assign cmdRd    = isReadOp(inByte);
  // decode of the held opcode in the data phase
  assign opIsAddr  = (opcode == OP_ADDR);
  assign opIsReset = (opcode == OP_RESET);

  always_comb begin
    stb          = '0;
    stb.shiftIn  = sclkRise;
    stb.latchOp  = cmdDone;
    stb.loadOut  = busRd;
    stb.shiftOut = sclkRise && !selSync && readActive;
    stb.wrAddr   = dataDone && opIsAddr;
    stb.clrAddr  = dataDone && opIsReset && (inByte == RESET_KEY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      cmdDone    <= 1'b0;
      dataDone   <= 1'b0;
      wrArm      <= 1'b0;
      readActive <= 1'b0;
      busWr      <= 1'b0;
      busRd      <= 1'b0;
      evtClr     <= 1'b0;
      softRst    <= 1'b0;
    end else begin
      if (selEdge)                            bitCnt <= '0;
      else if (sclkRise && bitCnt != FULL_CNT) bitCnt <= bitCnt + 1'b1;

      cmdDone  <= byteEnd && selSync;
      dataDone <= byteEnd && !selSync && wrArm;

      busWr   <= dataDone && !opIsAddr && !opIsReset;
      softRst <= dataDone && opIsReset && (inByte == RESET_KEY);
      evtClr  <= cmdDone && cmdClr && addrMatch;
      busRd   <= cmdDone && cmdRd && addrMatch;

      if (cmdDone) begin
        wrArm      <= cmdAddr || cmdReset || (cmdWr && addrMatch);
        readActive <= cmdRd && addrMatch;
      end
      if (dataDone) wrArm <= 1'b0;
      if (selEdge && selSync) begin
        wrArm      <= 1'b0;
        readActive <= 1'b0;
      end
    end
  end

  assign sdoEn = readActive && !selSync;
endmodule

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdiSync,
  input  logic [ADDR_W-1:0] strapAddr,
  input  logic [BYTE_W-1:0] busRdata,
  output logic [BYTE_W-1:0] inByte,
  output logic [BYTE_W-1:0] opcode,
  output logic [ADDR_W-1:0] chipAddr,
  output logic              addrMatch,
  output logic              sdoBit
);
  logic [BYTE_W-1:0] outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inByte   <= '0;
      opcode   <= '0;
      chipAddr <= '0;
      outReg   <= '0;
      sdoBit   <= 1'b0;
    end else begin
      if (stb.shiftIn) inByte <= {inByte[BYTE_W-2:0], sdiSync};
      if (stb.latchOp) opcode <= inByte;
      if (stb.clrAddr)     chipAddr <= '0;
      else if (stb.wrAddr) chipAddr <= inByte[ADDR_W-1:0];
      if (stb.loadOut) begin
        outReg <= busRdata;
        sdoBit <= 1'b0;
      end else if (stb.shiftOut) begin
        sdoBit <= outReg[BYTE_W-1];
        outReg <= {outReg[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign addrMatch = (chipAddr == strapAddr);
endmodule

// File: rtl/tri_serial_slave.sv
module tri_serial_slave
  import tsr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] strapAddr,
  input  logic              selIn,
  input  logic              sclkIn,
  input  logic              sdiIn,
  output logic              sdoOut,
  output logic              sdoEn,
  output logic [BYTE_W-1:0] busAddr,
  output logic [BYTE_W-1:0] busWdata,
  output logic              busWr,
  output logic              busRd,
  input  logic [BYTE_W-1:0] busRdata,
  output logic              evtClr,
  output logic              softRst
);
  dpStrobe_t stb;
  logic [BYTE_W-1:0] inByte, opcode;
  logic [ADDR_W-1:0] chipAddr;
  logic addrMatch, sdiSync, selSync;

  tsr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .selIn(selIn), .sclkIn(sclkIn), .sdiIn(sdiIn),
    .inByte(inByte), .opcode(opcode), .addrMatch(addrMatch), .stb(stb),
    .sdiSync(sdiSync), .selSync(selSync), .busWr(busWr), .busRd(busRd),
    .evtClr(evtClr), .softRst(softRst), .sdoEn(sdoEn)
  );

  tsr_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiSync(sdiSync),
    .strapAddr(strapAddr), .busRdata(busRdata), .inByte(inByte),
    .opcode(opcode), .chipAddr(chipAddr), .addrMatch(addrMatch),
    .sdoBit(sdoOut)
  );

  assign busAddr  = opcode;
  assign busWdata = inByte;
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busRd,
  input logic              evtClr,
  input logic              softRst,
  input logic              sdoEn,
  input logic              selSync,
  input logic              addrMatch,
  input logic [ADDR_W-1:0] chipAddr
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busWr, busRd, evtClr, softRst})); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> !busWr); // R10
  AST_WR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> addrMatch); // R6
  AST_RD_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> addrMatch); // R6
  AST_RESET_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> (chipAddr == '0)); // R7
  AST_OE_DATA_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !selSync); // R4
endmodule

bind tri_serial_slave tsr_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .evtClr(evtClr),
  .softRst(softRst), .sdoEn(sdoEn), .selSync(selSync),
  .addrMatch(addrMatch), .chipAddr(chipAddr)
);

// File: tb/tri_serial_slave_tb_top.sv
`timescale 1ns/1ps
module tri_serial_slave_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] strapAddr = 3'd5;
  logic selIn = 1'b1, sclkIn = 1'b0, sdiIn = 1'b0;
  logic sdoOut, sdoEn, busWr, busRd, evtClr, softRst;
  logic [7:0] busAddr, busWdata, busRdata;

  int total = 0, bad = 0;
  int wrCnt = 0, rdCnt = 0, evtCnt = 0, rstCnt = 0, multiCnt = 0;
  logic [7:0] lastWrAddr = '0, lastWrData = '0, lastRdAddr = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  tri_serial_slave dut_i (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .selIn(selIn),
    .sclkIn(sclkIn), .sdiIn(sdiIn), .sdoOut(sdoOut), .sdoEn(sdoEn),
    .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .busRdata(busRdata), .evtClr(evtClr), .softRst(softRst)
  );

  // register bus model: read value is a fixed function of the address
  assign busRdata = busAddr * 8'd7 + 8'd3;

  always @(posedge clk) begin
    if (busWr) begin wrCnt <= wrCnt + 1; lastWrAddr <= busAddr; lastWrData <= busWdata; end
    if (busRd) begin rdCnt <= rdCnt + 1; lastRdAddr <= busAddr; end
    if (evtClr) evtCnt <= evtCnt + 1;
    if (softRst) rstCnt <= rstCnt + 1;
    if ((32'(busWr) + 32'(busRd) + 32'(evtClr) + 32'(softRst)) > 1) multiCnt <= multiCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n, output logic [7:0] got,
                          output bit oeAll, output bit oeAny);
    got = '0; oeAll = 1; oeAny = 0;
    for (int i = 7; i > 7 - n; i--) begin
      sdiIn = b[i];
      halfWait();
      sclkIn = 1'b1;
      halfWait();
      got[i] = sdoOut;
      oeAll &= sdoEn; oeAny |= sdoEn;
      sclkIn = 1'b0;
    end
  endtask

  // command byte then data byte; select raised at the end
  task automatic xfer(input logic [7:0] op, input logic [7:0] data,
                      output logic [7:0] rd, output bit oeAll, output bit oeAny);
    logic [7:0] dummy; bit a, b;
    selIn = 1'b1; halfWait();
    sendBits(op, 8, dummy, a, b);
    halfWait();
    selIn = 1'b0; halfWait();
    sendBits(data, 8, rd, oeAll, oeAny);
    halfWait();
    selIn = 1'b1; halfWait(); halfWait();
  endtask

  task automatic cmdOnly(input logic [7:0] op);
    logic [7:0] dummy; bit a, b;
    selIn = 1'b1; halfWait();
    sendBits(op, 8, dummy, a, b);
    halfWait(); halfWait();
    selIn = 1'b0; halfWait();
    selIn = 1'b1; halfWait();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd; bit oeAll, oeAny; int w0, r0, e0, s0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    check(!sdoEn && !busWr && !busRd && !evtClr && !softRst, "R12 reset outputs",
          {sdoEn, busWr, busRd, evtClr, softRst}, 0);

    // R6 / R12: address register is 0, strap is 5, so commands are ignored
    w0 = wrCnt; r0 = rdCnt; e0 = evtCnt;
    xfer(8'h0E, 8'hAA, rd, oeAll, oeAny);
    check(wrCnt == w0, "R6 write ignored before address", wrCnt - w0, 0);
    xfer(8'h3D, 8'h00, rd, oeAll, oeAny);
    check(rdCnt == r0 && !oeAny, "R6 read ignored before address", rdCnt - r0, 0);
    cmdOnly(8'h13);
    check(evtCnt == e0, "R6 clear ignored before address", evtCnt - e0, 0);

    // R5: wrong address loaded, still ignored; right one enables
    xfer(8'hFD, 8'h03, rd, oeAll, oeAny);
    w0 = wrCnt;
    xfer(8'h0E, 8'h11, rd, oeAll, oeAny);
    check(wrCnt == w0, "R5 mismatched address blocks write", wrCnt - w0, 0);
    xfer(8'hFD, 8'hFD, rd, oeAll, oeAny);  // bits 2:0 = 5
    w0 = wrCnt;
    xfer(8'h0E, 8'h5A, rd, oeAll, oeAny);
    check(wrCnt == w0 + 1 && lastWrAddr == 8'h0E && lastWrData == 8'h5A,
          "R5 matched address enables write", {lastWrAddr, lastWrData}, 16'h0E5A);

    // R1 R2 write sweep
    for (int i = 0; i < 64; i++) begin
      logic [7:0] op, d;
      op = 8'(i % 32);
      if (op == 8'h13) op = 8'h12;
      d = 8'(i * 37 + 1);
      w0 = wrCnt;
      xfer(op, d, rd, oeAll, oeAny);
      check(wrCnt == w0 + 1 && lastWrAddr == op && lastWrData == d,
            "R1 R2 write strobe", {lastWrAddr, lastWrData}, {op, d});
      check(!oeAny, "R4 no drive during write", 32'(oeAny), 0);
    end

    // R3 R4 read sweep
    for (int i = 0; i < 32; i++) begin
      logic [7:0] op, exp;
      op = 8'h30 + 8'(i);
      exp = op * 8'd7 + 8'd3;
      r0 = rdCnt;
      xfer(op, 8'h00, rd, oeAll, oeAny);
      check(rd == exp, "R3 read data", rd, exp);
      check(rdCnt == r0 + 1 && lastRdAddr == op, "R3 read strobe", lastRdAddr, op);
      check(oeAll, "R4 drive during read", 32'(oeAll), 1);
      check(!sdoEn, "R4 released after select rises", 32'(sdoEn), 0);
    end

    // R9 unknown opcodes
    begin
      logic [7:0] unk [5] = '{8'h20, 8'h2F, 8'h50, 8'hA0, 8'hFC};
      for (int i = 0; i < 5; i++) begin
        w0 = wrCnt; r0 = rdCnt; e0 = evtCnt; s0 = rstCnt;
        xfer(unk[i], 8'h33, rd, oeAll, oeAny);
        check(wrCnt == w0 && rdCnt == r0 && evtCnt == e0 && rstCnt == s0 && !oeAny,
              "R9 unknown opcode ignored", 32'(unk[i]), 0);
      end
    end

    // R8 event clear
    w0 = wrCnt; e0 = evtCnt;
    cmdOnly(8'h13);
    check(evtCnt == e0 + 1 && wrCnt == w0, "R8 event clear pulse", evtCnt - e0, 1);

    // R11 partial command byte discarded by select change
    begin
      logic [7:0] dmy; bit a, b;
      selIn = 1'b1; halfWait();
      sendBits(8'hFF, 3, dmy, a, b);
      halfWait();
      selIn = 1'b0; halfWait();
      selIn = 1'b1; halfWait();
    end
    w0 = wrCnt;
    xfer(8'h0F, 8'hC3, rd, oeAll, oeAny);
    check(wrCnt == w0 + 1 && lastWrAddr == 8'h0F && lastWrData == 8'hC3,
          "R11 command after partial byte", {lastWrAddr, lastWrData}, 16'h0FC3);
    // R11 partial data byte gives no write
    begin
      logic [7:0] dmy; bit a, b;
      w0 = wrCnt;
      selIn = 1'b1; halfWait();
      sendBits(8'h02, 8, dmy, a, b);
      halfWait();
      selIn = 1'b0; halfWait();
      sendBits(8'hF0, 5, dmy, a, b);
      halfWait();
      selIn = 1'b1; halfWait(); halfWait();
      check(wrCnt == w0, "R11 partial data byte dropped", wrCnt - w0, 0);
    end

    // R7 software reset
    s0 = rstCnt;
    xfer(8'hFE, 8'h00, rd, oeAll, oeAny);
    check(rstCnt == s0, "R7 wrong key no reset", rstCnt - s0, 0);
    w0 = wrCnt;
    xfer(8'h0E, 8'h77, rd, oeAll, oeAny);
    check(wrCnt == w0 + 1, "R7 wrong key keeps address", wrCnt - w0, 1);
    xfer(8'hFE, 8'hFF, rd, oeAll, oeAny);
    check(rstCnt == s0 + 1, "R7 reset pulse", rstCnt - s0, 1);
    w0 = wrCnt;
    xfer(8'h0E, 8'h77, rd, oeAll, oeAny);
    check(wrCnt == w0, "R7 address cleared by reset", wrCnt - w0, 0);
    xfer(8'hFD, 8'h05, rd, oeAll, oeAny);
    xfer(8'h02, 8'h0F, rd, oeAll, oeAny);
    check(wrCnt == w0 + 1 && lastWrAddr == 8'h02 && lastWrData == 8'h0F,
          "R5 address reload after reset", {lastWrAddr, lastWrData}, 16'h020F);

    // R10 strobe exclusivity over the whole run
    check(multiCnt == 0, "R10 strobes exclusive", multiCnt, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule